// File: doc/BRIEF.md
# Frame Marker Suspend Monitor

This block sits next to the receive path of a full-speed USB device and keeps frame timing alive. It watches the start-of-frame strobe that the packet logic delivers. When real markers stop arriving, it produces a pseudo start-of-frame tick once per frame interval (1 ms by default). Each interval that ends with no real marker counts as one miss. When the third consecutive miss occurs, the block declares the bus suspended.

While suspended, a resume indication or a real marker returns the bus to the awake state. The miss count then starts again from zero. A bus reset restarts everything and forces the awake state. Line-state decoding is done elsewhere: resume and bus reset arrive here as single-cycle strobes.

Top module: `sof_suspend_monitor`

## Requirements
- R1: Coming out of reset, every output is low and the bus status reads awake (0).
- R2: `sof_seen_o` is high for exactly one cycle, in the cycle after each cycle in which `sof_i` is high.
- R3: With no restart event, `psof_o` pulses for one cycle `TICK_CYCLES` cycles after the last restart event, and again every `TICK_CYCLES` cycles after that.
- R4: A real marker on `sof_i` restarts the frame interval and clears the miss count. The pulse that the earlier interval would have produced does not occur.
- R5: On the third consecutive expiry of the interval without a real marker, `suspend_o` pulses for one cycle in the same cycle as that `psof_o` pulse, and `bus_suspended_o` becomes 1 from that cycle on.
- R6: While suspended, further expiries still pulse `psof_o`, but `suspend_o` stays low.
- R7: `resume_i` while suspended gives a one-cycle `resume_o` pulse and sets `bus_suspended_o` to 0 in the same cycle. It also restarts the interval and clears the miss count, so a later suspend needs three new misses.
- R8: `sof_i` while suspended also gives a one-cycle `resume_o` pulse and returns the status to awake.
- R9: `resume_i` while awake is ignored: `resume_o` stays low and the `psof_o` timing is unchanged.
- R10: `bus_reset_i` restarts the interval, clears the miss count and forces the awake state without a `resume_o` pulse. It takes priority over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Real start-of-frame marker strobe |
| resume_i | input | 1 | Resume signalling detected strobe |
| bus_reset_i | input | 1 | Bus reset detected strobe |
| sof_seen_o | output | 1 | Real marker seen strobe |
| psof_o | output | 1 | Pseudo start-of-frame tick strobe |
| suspend_o | output | 1 | Awake-to-suspend change strobe |
| resume_o | output | 1 | Suspend-to-awake change strobe |
| bus_suspended_o | output | 1 | Bus status: 0 awake, 1 suspended |

## Verification
The hardest situations to reach are the suspended state, and the boundary where a marker arrives just before an expiry. Both need long, precisely counted stretches with no markers. The bench shrinks `TICK_CYCLES` to 20 so that three misses take 60 cycles. Each scenario starts from a marker or bus reset pulse at a known edge and counts cycles from there. Expected pulses are then sampled at exact offsets, one cycle before and at each interval boundary. This covers waking by both routes and the fresh three-miss count that must follow.

// File: rtl/sof_mon_pkg.sv
package sof_mon_pkg;
  typedef enum logic {
    LINK_AWAKE     = 1'b0,
    LINK_SUSPENDED = 1'b1
  } link_state_e;
endpackage

// File: rtl/sof_mon_frame_timer.sv
module sof_mon_frame_timer #(
  parameter int unsigned TICK_CYCLES = 48000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last  = (cnt_q == LAST);
  // a restart in the terminal cycle suppresses that tick
  assign expire_o = at_last && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i || at_last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sof_mon_miss_counter.sv
module sof_mon_miss_counter #(
  parameter int unsigned MISS_LIMIT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic miss_i,
  output logic limit_hit_o
);
  localparam int unsigned MW = $clog2(MISS_LIMIT + 1);
  localparam logic [MW-1:0] LIMIT   = MW'(MISS_LIMIT);
  localparam logic [MW-1:0] PRE_LIM = MW'(MISS_LIMIT - 1);

  logic [MW-1:0] cnt_q;

  assign limit_hit_o = miss_i && !clear_i && (cnt_q == PRE_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (miss_i && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;  // saturates at the limit
    end
  end
endmodule

// File: rtl/sof_mon_link_fsm.sv
module sof_mon_link_fsm
  import sof_mon_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        force_awake_i,
  input  logic        wake_i,
  input  logic        limit_hit_i,
  output link_state_e state_o,
  output logic        suspend_o,
  output logic        resume_o
);
  link_state_e state_q, state_d;
  logic        susp_d, res_d;

  always_comb begin
    state_d = state_q;
    susp_d  = 1'b0;
    res_d   = 1'b0;
    if (force_awake_i) begin
      state_d = LINK_AWAKE;
    end else if (state_q == LINK_SUSPENDED) begin
      if (wake_i) begin
        state_d = LINK_AWAKE;
        res_d   = 1'b1;
      end
    end else if (limit_hit_i) begin
      state_d = LINK_SUSPENDED;
      susp_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= LINK_AWAKE;
      suspend_o <= 1'b0;
      resume_o  <= 1'b0;
    end else begin
      state_q   <= state_d;
      suspend_o <= susp_d;
      resume_o  <= res_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/sof_suspend_monitor.sv
module sof_suspend_monitor
  import sof_mon_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 48000,
  parameter int unsigned MISS_LIMIT  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  input  logic resume_i,
  input  logic bus_reset_i,
  output logic sof_seen_o,
  output logic psof_o,
  output logic suspend_o,
  output logic resume_o,
  output logic bus_suspended_o
);
  link_state_e state;
  logic        suspended, restart, expire, limit_hit;

  assign suspended = (state == LINK_SUSPENDED);
  // resume only counts as activity while suspended
  assign restart   = sof_i || bus_reset_i || (resume_i && suspended);

  sof_mon_frame_timer #(.TICK_CYCLES(TICK_CYCLES)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .expire_o (expire)
  );

  sof_mon_miss_counter #(.MISS_LIMIT(MISS_LIMIT)) i_miss (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (restart),
    .miss_i     (expire),
    .limit_hit_o(limit_hit)
  );

  sof_mon_link_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .force_awake_i(bus_reset_i),
    .wake_i       (sof_i || resume_i),
    .limit_hit_i  (limit_hit),
    .state_o      (state),
    .suspend_o    (suspend_o),
    .resume_o     (resume_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sof_seen_o <= 1'b0;
      psof_o     <= 1'b0;
    end else begin
      sof_seen_o <= sof_i;
      psof_o     <= expire;
    end
  end

  assign bus_suspended_o = suspended;
endmodule

// File: rtl/sof_suspend_monitor_chk.sv
module sof_suspend_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sof_i,
  input logic bus_reset_i,
  input logic sof_seen_o,
  input logic psof_o,
  input logic suspend_o,
  input logic resume_o,
  input logic bus_suspended_o
);
  a_r2_sof_seen_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> sof_seen_o);
  a_r4_sof_blocks_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i || bus_reset_i) |=> !psof_o);
  a_r5_suspend_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> (psof_o && bus_suspended_o && !$past(bus_suspended_o)));
  a_r6_no_double_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_suspended_o) |-> !suspend_o);
  a_r7_resume_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (!bus_suspended_o && $past(bus_suspended_o)));
  a_r10_reset_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (!bus_suspended_o && !resume_o && !suspend_o));
  a_r5_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(suspend_o && resume_o));
endmodule

bind sof_suspend_monitor sof_suspend_monitor_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sof_i          (sof_i),
  .bus_reset_i    (bus_reset_i),
  .sof_seen_o     (sof_seen_o),
  .psof_o         (psof_o),
  .suspend_o      (suspend_o),
  .resume_o       (resume_o),
  .bus_suspended_o(bus_suspended_o)
);

// File: tb/test_sof_suspend_monitor.sv
module test_sof_suspend_monitor;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sof_i = 1'b0, resume_i = 1'b0, bus_reset_i = 1'b0;
  logic sof_seen_o, psof_o, suspend_o, resume_o, bus_suspended_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sof_suspend_monitor #(.TICK_CYCLES(T), .MISS_LIMIT(3)) i_sof_suspend_monitor (
    .clk_i(clk), .rst_ni(rst_ni), .sof_i(sof_i), .resume_i(resume_i),
    .bus_reset_i(bus_reset_i), .sof_seen_o(sof_seen_o), .psof_o(psof_o),
    .suspend_o(suspend_o), .resume_o(resume_o), .bus_suspended_o(bus_suspended_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_sof();
    sof_i = 1'b1; step(1); sof_i = 1'b0;
  endtask
  task automatic pulse_resume();
    resume_i = 1'b1; step(1); resume_i = 1'b0;
  endtask
  task automatic pulse_bus_reset();
    bus_reset_i = 1'b1; step(1); bus_reset_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sof_seen", sof_seen_o, 1'b0);
    chk("R1 psof", psof_o, 1'b0);
    chk("R1 suspend", suspend_o, 1'b0);
    chk("R1 resume", resume_o, 1'b0);
    chk("R1 status", bus_suspended_o, 1'b0);
  endtask

  task automatic t_sof_seen();
    pulse_sof();
    chk("R2 sof_seen high", sof_seen_o, 1'b1);
    chk("R2 no psof", psof_o, 1'b0);
    step(1);
    chk("R2 sof_seen single", sof_seen_o, 1'b0);
  endtask

  task automatic t_psof_period();
    pulse_sof();
    step(T - 1);
    chk("R3 before first tick", psof_o, 1'b0);
    step(1);
    chk("R3 first tick", psof_o, 1'b1);
    step(1);
    chk("R3 tick single", psof_o, 1'b0);
    step(T - 1);
    chk("R3 second tick", psof_o, 1'b1);
    chk("R3 no suspend yet", suspend_o, 1'b0);
  endtask

  task automatic t_sof_restart();
    // two misses are pending; a marker must clear them
    pulse_sof();
    step(T / 2 - 1);
    pulse_sof();
    step(T / 2);
    chk("R4 old tick gone", psof_o, 1'b0);
    step(T / 2 - 1);
    chk("R4 before new tick", psof_o, 1'b0);
    step(1);
    chk("R4 new tick", psof_o, 1'b1);
    chk("R4 misses cleared", suspend_o, 1'b0);
  endtask

  task automatic t_suspend();
    pulse_sof();
    step(2 * T);
    chk("R5 second miss", psof_o, 1'b1);
    chk("R5 still awake", bus_suspended_o, 1'b0);
    step(T - 1);
    chk("R5 before third", suspend_o, 1'b0);
    step(1);
    chk("R5 third tick", psof_o, 1'b1);
    chk("R5 suspend strobe", suspend_o, 1'b1);
    chk("R5 status", bus_suspended_o, 1'b1);
    step(1);
    chk("R5 strobe single", suspend_o, 1'b0);
    step(T - 1);
    chk("R6 tick while suspended", psof_o, 1'b1);
    chk("R6 no second strobe", suspend_o, 1'b0);
    chk("R6 still suspended", bus_suspended_o, 1'b1);
  endtask

  task automatic t_resume_wakes();
    step(3);
    pulse_resume();
    chk("R7 resume strobe", resume_o, 1'b1);
    chk("R7 awake", bus_suspended_o, 1'b0);
    step(1);
    chk("R7 strobe single", resume_o, 1'b0);
    step(T - 2);
    chk("R7 timer restarted", psof_o, 1'b0);
    step(1);
    chk("R7 tick after resume", psof_o, 1'b1);
    chk("R7 no early suspend", suspend_o, 1'b0);
    step(T);
    chk("R7 second new miss", suspend_o, 1'b0);
    step(T);
    chk("R7 suspend after three new", suspend_o, 1'b1);
  endtask

  task automatic t_sof_wakes();
    step(2);
    pulse_sof();
    chk("R8 resume strobe", resume_o, 1'b1);
    chk("R8 awake", bus_suspended_o, 1'b0);
    chk("R8 sof_seen", sof_seen_o, 1'b1);
  endtask

  task automatic t_resume_ignored();
    step(4);
    pulse_resume();
    chk("R9 no resume strobe", resume_o, 1'b0);
    chk("R9 still awake", bus_suspended_o, 1'b0);
    step(T - 6);
    chk("R9 before tick", psof_o, 1'b0);
    step(1);
    chk("R9 tick unmoved", psof_o, 1'b1);
  endtask

  task automatic t_bus_reset();
    pulse_sof();
    step(3 * T);
    chk("R10 setup suspended", bus_suspended_o, 1'b1);
    step(2);
    resume_i = 1'b1;  // bus reset has priority over a wake
    pulse_bus_reset();
    resume_i = 1'b0;
    chk("R10 awake", bus_suspended_o, 1'b0);
    chk("R10 no resume strobe", resume_o, 1'b0);
    step(T - 1);
    chk("R10 timer restarted", psof_o, 1'b0);
    step(1);
    chk("R10 tick", psof_o, 1'b1);
    step(T);
    chk("R10 misses cleared", suspend_o, 1'b0);
    step(T);
    chk("R10 suspend after three", suspend_o, 1'b1);
  endtask

  initial begin
    step(3);
    t_reset();
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_sof_seen();
    t_psof_period();
    t_sof_restart();
    t_suspend();
    t_resume_wakes();
    t_sof_wakes();
    t_resume_ignored();
    t_bus_reset();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule